// File: doc/BRIEF.md
# Semi-Decoupled Four-Phase Latch Controller

This block controls one storage stage of a de-synchronised pipeline. Its input channel is a request/acknowledge pair, and its output channel is a second such pair. Both channels use the four-phase bundled-data convention: data is made valid and the request rises, the acknowledge rises, the request falls, and then the acknowledge falls. The controller decides when the stage's data latch may capture, when the captured word is offered downstream, and when the upstream sender is released.

The control is made of two state-holding gates, each written as set and reset logic with `next = set | (state & ~reset)`. The input-side gate has three inputs: it sets on `reqIn & ~reqOut` and resets on `~reqIn & reqOut & ackOut`. The output-side gate is asymmetric with two inputs: it sets on `ackIn & ~ackOut` and resets on `~ackIn`. The latch is open while the input side has accepted a token and the output side has not yet raised its request. The two gates give four control states. A cycle-sampled model stands in for the free-running gates, so each gate settles one clock after its inputs change. An active-low reset puts the stage in an empty, closed state.

Top module: `sdlc_top`

## Requirements
- R1: While reset is asserted, and in the first sample after it, ackIn, reqOut and latchEn are 0.
- R2: ackIn rises one cycle after a sample in which reqIn is 1 and reqOut is 0, and rises at no other time.
- R3: ackIn falls one cycle after a sample in which reqIn is 0, reqOut is 1 and ackOut is 1, and falls at no other time.
- R4: reqOut rises one cycle after a sample in which ackIn is 1 and ackOut is 0, and rises at no other time.
- R5: reqOut falls one cycle after a sample in which ackIn is 0, and falls at no other time.
- R6: latchEn is 1 exactly when ackIn is 1 and reqOut is 0.
- R7: When reqOut rises, dataOut equals the dataIn value that was present in the preceding cycle, which was the last cycle with latchEn at 1.
- R8: dataOut does not change in a cycle that follows a cycle with latchEn at 0.
- R9: When a sender and a receiver both follow the four-phase order, every word is delivered exactly once, in the order it was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the state-holding gates |
| rstN | input | 1 | Asynchronous active-low reset to the empty state |
| reqIn | input | 1 | Request from the upstream stage |
| ackIn | output | 1 | Acknowledge to the upstream stage |
| dataIn | input | DATA_W | Bundled data from upstream |
| reqOut | output | 1 | Request to the downstream stage |
| ackOut | input | 1 | Acknowledge from the downstream stage |
| dataOut | output | DATA_W | Latched data offered downstream |
| latchEn | output | 1 | Enable of the stage latch |

## Verification
The bench builds the block with DATA_W at 4. At this width a long pseudo-random walk over reqIn, ackOut and dataIn reaches every pair of control state and input many times, including input orders that break the protocol, and sees every data value captured and held. Expected outputs come from the requirement equations, computed in the bench. A second phase drives a protocol-following sender and receiver and compares the word order on both sides.

// File: rtl/sdlc_pkg.sv
package sdlc_pkg;
  typedef struct packed {
    logic latchOpen;
    logic tokenOut;
  } ctrlStrobes_t;
endpackage

// File: rtl/sdlc_cgate3.sv
module sdlc_cgate3 (
  input  logic clk,
  input  logic rstN,
  input  logic a,
  input  logic b,
  input  logic c,
  output logic z
);
  logic zSet;
  logic zReset;
  assign zSet   = a & ~b;
  assign zReset = ~a & b & c;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) z <= 1'b0;
    else       z <= zSet | (z & ~zReset);
  end
endmodule

// File: rtl/sdlc_cgate2.sv
module sdlc_cgate2 (
  input  logic clk,
  input  logic rstN,
  input  logic a,
  input  logic b,
  output logic z
);
  logic zSet;
  logic zReset;
  assign zSet   = a & ~b;
  assign zReset = ~a;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) z <= 1'b0;
    else       z <= zSet | (z & ~zReset);
  end
endmodule

// File: rtl/sdlc_ctrl.sv
module sdlc_ctrl
  import sdlc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqIn,
  input  logic         ackOut,
  output logic         ackIn,
  output ctrlStrobes_t strobes
);
  logic accepted;
  logic offered;

  sdlc_cgate3 uInGate (
    .clk (clk),
    .rstN(rstN),
    .a   (reqIn),
    .b   (offered),
    .c   (ackOut),
    .z   (accepted)
  );

  sdlc_cgate2 uOutGate (
    .clk (clk),
    .rstN(rstN),
    .a   (accepted),
    .b   (ackOut),
    .z   (offered)
  );

  assign ackIn             = accepted;
  assign strobes.tokenOut  = offered;
  assign strobes.latchOpen = accepted & ~offered;

  a_r2_ack_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accepted) |-> $past(reqIn && !offered));
  a_r3_ack_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(accepted) |-> $past(!reqIn && offered && ackOut));
  a_r4_req_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(offered) |-> $past(accepted && !ackOut));
  a_r5_req_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(offered) |-> $past(!accepted));
endmodule

// File: rtl/sdlc_datapath.sv
module sdlc_datapath
  import sdlc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] store;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  store <= '0;
    else if (strobes.latchOpen) store <= dataIn;
  end
  assign dataOut = store;

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.latchOpen) |-> $stable(dataOut));
endmodule

// File: rtl/sdlc_top.sv
module sdlc_top
  import sdlc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqIn,
  output logic              ackIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              reqOut,
  input  logic              ackOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              latchEn
);
  ctrlStrobes_t strobes;

  sdlc_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .reqIn  (reqIn),
    .ackOut (ackOut),
    .ackIn  (ackIn),
    .strobes(strobes)
  );

  sdlc_datapath #(.DATA_W(DATA_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .dataIn (dataIn),
    .dataOut(dataOut)
  );

  assign reqOut  = strobes.tokenOut;
  assign latchEn = strobes.latchOpen;

  a_r7_bundle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqOut) |-> dataOut == $past(dataIn));
endmodule

// File: tb/sim_sdlc_top.sv
module sim_sdlc_top;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqIn = 1'b0;
  logic ackOut = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic ackIn, reqOut, latchEn;
  logic [DW-1:0] dataOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdlc_top #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .ackIn(ackIn), .dataIn(dataIn),
    .reqOut(reqOut), .ackOut(ackOut), .dataOut(dataOut), .latchEn(latchEn)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic aExp, rExp, aN, rN;
    logic [DW-1:0] dExp;
    logic [15:0] lfsr;
    logic [DW-1:0] sent [0:63];
    int nSent, nGot, sendIdx;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 ackIn", int'(ackIn), 0);
    check("R1 reqOut", int'(reqOut), 0);
    check("R1 latchEn", int'(latchEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ackIn after release", int'(ackIn), 0);
    check("R1 reqOut after release", int'(reqOut), 0);

    // Random walk: every state/input pair, protocol or not.
    aExp = 1'b0; rExp = 1'b0; dExp = '0;
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      check("R2/R3 ackIn", int'(ackIn), int'(aExp));
      check("R4/R5 reqOut", int'(reqOut), int'(rExp));
      check("R6 latchEn", int'(latchEn), int'(aExp & ~rExp));
      check("R7/R8 dataOut", int'(dataOut), int'(dExp));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reqIn  = lfsr[0];
      ackOut = lfsr[3];
      dataIn = lfsr[9:6];
      // R2/R3: three-input gate; R4/R5: two-input gate
      aN = (reqIn & ~rExp) | (aExp & ~(~reqIn & rExp & ackOut));
      rN = (aExp & ~ackOut) | (rExp & aExp);
      if (aExp & ~rExp) dExp = dataIn;  // R7 capture, R8 hold otherwise
      aExp = aN;
      rExp = rN;
      @(negedge clk);
    end

    // R9: protocol-following sender and receiver.
    rstN = 1'b0; reqIn = 1'b0; ackOut = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    nSent = 0; nGot = 0; sendIdx = 0;
    for (int k = 0; k < 64; k++) sent[k] = DW'((k * 7 + 3) % 16);
    for (int cyc = 0; cyc < 2000 && nGot < 64; cyc++) begin
      if (reqOut && !ackOut) begin
        check("R9 word order", int'(dataOut), int'(sent[nGot]));
        nGot++;
        ackOut = 1'b1;
      end else if (!reqOut && ackOut) begin
        ackOut = 1'b0;
      end
      if (!reqIn && !ackIn && sendIdx < 64) begin
        dataIn = sent[sendIdx];
        sendIdx++;
        reqIn = 1'b1;
        nSent++;
      end else if (reqIn && ackIn) begin
        reqIn = 1'b0;
      end
      @(negedge clk);
    end
    check("R9 words delivered", nGot, 64);
    check("R9 words sent", nSent, 64);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule